// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on the host side of a configuration fabric and turns simple CPU port accesses into configuration-space transactions. The CPU sees eight consecutive ports. The lower four hold a 32-bit selector register. The upper four form a data window. A write to the selector picks the target bus, the device/function and the dword-aligned register. An access through the data window then becomes one configuration request that carries bus, devfn, byte offset, size and data.

Writes complete as soon as the request is issued. Reads wait for the target's response-valid, and the bridge holds its CPU ready low until then. Window accesses are dropped in two cases: the selector's enable bit is clear, or its two low bits are not zero. A dropped read returns all ones at the requested width. So does a read that the fabric reports as having no responder.

Top module: `cfg_port_bridge`

## Requirements
- R1: The selector register resets to zero. A CPU write at ports 0..3 stores all 32 bits, and a read at ports 0..3 returns the last value stored. Nothing else changes it.
- R2: Port offsets 0..3 (`cpu_addr[2]`=0) reach the selector and offsets 4..7 (`cpu_addr[2]`=1) reach the data window. The size code is 00 for a byte, 01 for a halfword and 10 for a word. Data is right-aligned, and read data above the requested width is zero.
- R3: A window access made while selector bit 31 is clear issues no request. A read made this way returns all ones at the requested width.
- R4: A window access made while selector bits [1:0] are not both zero issues no request. A read made this way returns all ones at the requested width.
- R5: The forwarded bus number is selector bits [23:16] and the forwarded devfn is selector bits [15:8]. The device is devfn[7:3] and the function is devfn[2:0].
- R6: The forwarded byte offset is {selector[7:2], cpu_addr[1:0]}.
- R7: Values are little-endian. Forwarded write data is the CPU data truncated to the access width, with its bit 7:0 going to the lowest offset. Read data is the target value masked to the access width.
- R8: A read that the fabric answers with `cfg_miss` set returns all ones at the requested width.
- R9: Each accepted window access that is not dropped produces exactly one `cfg_req` pulse of one cycle.
- R10: `cpu_ready` is low from the accepting edge until the access completes. `cpu_done` is a one-cycle pulse that carries `cpu_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, taken when cpu_ready is high |
| cpu_addr | input | 3 | Port offset: 0..3 selector, 4..7 data window |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 00 byte, 01 halfword, 10 word |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_ready | output | 1 | Bridge can take an access |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read result, valid with cpu_done |
| cfg_req | output | 1 | One-cycle configuration request strobe |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_devfn | output | 8 | Target device/function |
| cfg_off | output | 8 | Register byte offset |
| cfg_size | output | 2 | Access size code |
| cfg_wdata | output | 32 | Write data, masked to size |
| cfg_rvalid | input | 1 | Read response valid |
| cfg_miss | input | 1 | No responder for the read |
| cfg_rdata | input | 32 | Read response value |

## Verification
The hardest case to reach is proving that a dropped window access had no effect. A dropped write leaves nothing behind at the ports. The stimulus therefore first performs dropped writes under a disabled selector and under a misaligned selector. It then restores a valid selector and reads the same dword back, expecting the target's untouched bytes. Around each dropped access it also compares the request counter kept by the dummy targets. Sub-word reads use a target that always returns four bytes, so that the bridge's width masking is observable.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 32;
    localparam int EN_BIT = 31;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_RESP = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] bus;
        logic [BYTE_W-1:0] devfn;
        logic [BYTE_W-1:0] off;
        logic [1:0]        size;
        logic              we;
        logic [DATA_W-1:0] data;
    } cfg_xact_t;

    function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: width_mask = 32'h0000_00FF;
            SZ_HALF: width_mask = 32'h0000_FFFF;
            default: width_mask = 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/cfgb_addr_latch.sv
module cfgb_addr_latch
    import cfgb_pkg::*;
#(
    parameter int W = SEL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q,
    output logic         win_open
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= wdata;
    end

    assign win_open = q[EN_BIT] && (q[1:0] == 2'b00);

    AST_SEL_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> q == '0); // R1
    AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && !$past(rst)) |-> $stable(q)); // R1
endmodule

// File: rtl/cfgb_decode.sv
module cfgb_decode
    import cfgb_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [1:0]        port_lo,
    input  logic [1:0]        size,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output cfg_xact_t         xact
);
    always_comb begin
        xact.bus   = sel[23:16];
        xact.devfn = sel[15:8];
        xact.off   = {sel[7:2], port_lo};
        xact.size  = size;
        xact.we    = we;
        xact.data  = wdata & width_mask(size);
    end
endmodule

// File: rtl/cfgb_seq.sv
module cfgb_seq
    import cfgb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              is_data,
    input  logic              is_we,
    input  logic [1:0]        size,
    input  logic              win_open,
    input  logic [SEL_W-1:0]  sel_q,
    input  cfg_xact_t         xact_in,
    input  logic              rsp_valid,
    input  logic              rsp_miss,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              sel_we,
    output logic              strobe,
    output cfg_xact_t         xact_q
);
    seq_state_e        state;
    logic [DATA_W-1:0] rdata_q;
    logic              accept;

    assign accept    = cpu_req && (state == ST_IDLE);
    assign sel_we    = accept && !is_data && is_we;
    assign cpu_ready = (state == ST_IDLE);
    assign cpu_done  = (state == ST_RESP);
    assign cpu_rdata = rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            strobe  <= 1'b0;
            rdata_q <= '0;
            xact_q  <= '0;
        end else begin
            strobe <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (!is_data) begin
                            rdata_q <= is_we ? '0 : sel_q;
                            state   <= ST_RESP;
                        end else if (win_open) begin
                            xact_q  <= xact_in;
                            strobe  <= 1'b1;
                            rdata_q <= '0;
                            state   <= is_we ? ST_RESP : ST_WAIT;
                        end else begin
                            rdata_q <= is_we ? '0 : width_mask(size);
                            state   <= ST_RESP;
                        end
                    end
                end
                ST_WAIT: begin
                    if (rsp_valid) begin
                        rdata_q <= rsp_miss ? width_mask(xact_q.size)
                                            : (rsp_data & width_mask(xact_q.size));
                        state   <= ST_RESP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done); // R10
    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && rsp_valid) |=> (cpu_done && !cpu_ready)); // R10
    AST_NO_READY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> !cpu_ready); // R10
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
    import cfgb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic [2:0]  cpu_addr,
    input  logic        cpu_we,
    input  logic [1:0]  cpu_size,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_ready,
    output logic        cpu_done,
    output logic [31:0] cpu_rdata,
    output logic        cfg_req,
    output logic        cfg_we,
    output logic [7:0]  cfg_bus,
    output logic [7:0]  cfg_devfn,
    output logic [7:0]  cfg_off,
    output logic [1:0]  cfg_size,
    output logic [31:0] cfg_wdata,
    input  logic        cfg_rvalid,
    input  logic        cfg_miss,
    input  logic [31:0] cfg_rdata
);
    logic [SEL_W-1:0] sel_q;
    logic             win_open;
    logic             sel_we;
    cfg_xact_t        xact_c;
    cfg_xact_t        xact_q;

    cfgb_addr_latch #(.W(SEL_W)) u_sel (
        .clk(clk), .rst(rst), .wr_en(sel_we), .wdata(cpu_wdata),
        .q(sel_q), .win_open(win_open)
    );

    cfgb_decode u_dec (
        .sel(sel_q), .port_lo(cpu_addr[1:0]), .size(cpu_size),
        .we(cpu_we), .wdata(cpu_wdata), .xact(xact_c)
    );

    cfgb_seq u_seq (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .is_data(cpu_addr[2]),
        .is_we(cpu_we), .size(cpu_size), .win_open(win_open), .sel_q(sel_q),
        .xact_in(xact_c), .rsp_valid(cfg_rvalid), .rsp_miss(cfg_miss),
        .rsp_data(cfg_rdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata), .sel_we(sel_we), .strobe(cfg_req), .xact_q(xact_q)
    );

    assign cfg_we    = xact_q.we;
    assign cfg_bus   = xact_q.bus;
    assign cfg_devfn = xact_q.devfn;
    assign cfg_off   = xact_q.off;
    assign cfg_size  = xact_q.size;
    assign cfg_wdata = xact_q.data;

    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> sel_q[EN_BIT]); // R3
    AST_REQ_NEEDS_ALIGN: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> (sel_q[1:0] == 2'b00)); // R4
    AST_ROUTE_MATCH: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> (cfg_bus == sel_q[23:16] && cfg_devfn == sel_q[15:8])); // R5
    AST_OFFSET_MATCH: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> (cfg_off[7:2] == sel_q[7:2])); // R6
endmodule

// File: tb/cfg_port_bridge_bench.sv
`timescale 1ns/1ps
module cfg_port_bridge_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic [2:0]  cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'b10;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready, cpu_done;
    logic [31:0] cpu_rdata;
    logic        cfg_req, cfg_we;
    logic [7:0]  cfg_bus, cfg_devfn, cfg_off;
    logic [1:0]  cfg_size;
    logic [31:0] cfg_wdata;
    logic        cfg_rvalid = 1'b0;
    logic        cfg_miss = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int n_chk = 0, n_fail = 0;
    int req_cnt = 0, dbl_strobe = 0, ready_bad = 0, done_bad = 0;
    logic [7:0]  l_bus, l_devfn, l_off;
    logic [1:0]  l_size;
    logic        l_we;
    logic [31:0] l_wdata;
    logic [7:0]  mem [0:1][0:255];
    int          tmr = 0;
    int          t_sel = 0;
    logic        prev_req = 1'b0;
    logic [31:0] rd;
    int          base;

    always #4 clk = ~clk;

    cfg_port_bridge u_cfg_port_bridge (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .cpu_size(cpu_size), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn), .cfg_off(cfg_off), .cfg_size(cfg_size),
        .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid), .cfg_miss(cfg_miss),
        .cfg_rdata(cfg_rdata)
    );

    function automatic int target_of(input logic [7:0] b, input logic [7:0] d);
        if (b == 8'h00 && d == 8'h00) return 0;
        if (b == 8'h02 && d == 8'h1A) return 1;
        return -1;
    endfunction

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
    endfunction

    // Dummy targets: writes land at once, reads answer three cycles later
    // with four bytes from the offset (upper bytes left for the bridge to mask).
    always @(posedge clk) begin
        cfg_rvalid <= 1'b0;
        cfg_miss   <= 1'b0;
        prev_req   <= cfg_req;
        if (cfg_req && prev_req) dbl_strobe++;
        if (cfg_req) begin
            req_cnt++;
            l_bus = cfg_bus; l_devfn = cfg_devfn; l_off = cfg_off;
            l_size = cfg_size; l_we = cfg_we; l_wdata = cfg_wdata;
            t_sel = target_of(cfg_bus, cfg_devfn);
            if (cfg_we) begin
                if (t_sel >= 0)
                    for (int i = 0; i < nbytes(cfg_size); i++)
                        mem[t_sel][(cfg_off + i) & 8'hFF] = cfg_wdata[8*i +: 8];
            end else begin
                tmr = 3;
            end
        end else if (tmr > 0) begin
            tmr--;
            if (tmr == 0) begin
                cfg_rvalid <= 1'b1;
                if (t_sel < 0) begin
                    cfg_miss  <= 1'b1;
                    cfg_rdata <= 32'h1234_5678;
                end else begin
                    cfg_rdata <= {mem[t_sel][(l_off + 3) & 8'hFF], mem[t_sel][(l_off + 2) & 8'hFF],
                                  mem[t_sel][(l_off + 1) & 8'hFF], mem[t_sel][l_off]};
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [2:0] a, input logic we, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] r);
        int guard;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b1; cpu_addr = a; cpu_we = we; cpu_size = sz; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        guard = 0;
        while (!cpu_done && guard < 50) begin
            if (cpu_ready) ready_bad++;
            guard++;
            @(negedge clk);
        end
        if (cpu_ready) ready_bad++;
        r = cpu_rdata;
        @(negedge clk);
        if (cpu_done) done_bad++;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[0][i] = 8'(i) ^ 8'h3C;
            mem[1][i] = 8'(i) ^ 8'hC3;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 ready after reset", {31'd0, cpu_ready}, 32'd1);
        access(3'd0, 1'b0, 2'b10, 0, rd);
        check("R1 selector reset value", rd, 32'h0);

        access(3'd0, 1'b1, 2'b10, 32'h1234_5678, rd);
        access(3'd0, 1'b0, 2'b10, 0, rd);
        check("R1 selector readback", rd, 32'h1234_5678);
        access(3'd3, 1'b0, 2'b10, 0, rd);
        check("R2 selector at port 3", rd, 32'h1234_5678);

        access(3'd0, 1'b1, 2'b10, 32'h8000_0010, rd);
        base = req_cnt;
        access(3'd4, 1'b1, 2'b10, 32'hDEAD_BEEF, rd);
        check("R9 one request per write", 32'(req_cnt - base), 32'd1);
        check("R5 bus/devfn", {16'd0, l_bus, l_devfn}, 32'h0000_0000);
        check("R6 word offset", {24'd0, l_off}, 32'h10);
        check("R7 word write data", l_wdata, 32'hDEAD_BEEF);
        access(3'd4, 1'b0, 2'b10, 0, rd);
        check("R7 word readback", rd, 32'hDEAD_BEEF);
        access(3'd6, 1'b0, 2'b00, 0, rd);
        check("R6 byte offset", {24'd0, l_off}, 32'h12);
        check("R7 byte read lane", rd, 32'h0000_00AD);

        access(3'd6, 1'b1, 2'b01, 32'h1234_CAFE, rd);
        check("R7 half write truncated", l_wdata, 32'h0000_CAFE);
        access(3'd7, 1'b1, 2'b00, 32'hAAAA_AA55, rd);
        access(3'd4, 1'b0, 2'b10, 0, rd);
        check("R7 little-endian merge", rd, 32'h55FE_BEEF);
        access(3'd4, 1'b0, 2'b01, 0, rd);
        check("R2 half read masked", rd, 32'h0000_BEEF);

        access(3'd0, 1'b1, 2'b10, 32'h8002_1A44, rd);
        access(3'd5, 1'b0, 2'b01, 0, rd);
        check("R5 second target route", {16'd0, l_bus, l_devfn}, 32'h0000_021A);
        check("R6 offset from port 5", {24'd0, l_off}, 32'h45);
        check("R7 half read value", rd, 32'h0000_8586);

        access(3'd0, 1'b1, 2'b10, 32'h0002_1A44, rd);
        base = req_cnt;
        access(3'd4, 1'b1, 2'b10, 32'h1111_1111, rd);
        access(3'd4, 1'b0, 2'b10, 0, rd);
        check("R3 disabled word read", rd, 32'hFFFF_FFFF);
        access(3'd6, 1'b0, 2'b00, 0, rd);
        check("R3 disabled byte read", rd, 32'h0000_00FF);
        check("R3 no request while disabled", 32'(req_cnt - base), 32'd0);

        access(3'd0, 1'b1, 2'b10, 32'h8002_1A46, rd);
        access(3'd4, 1'b1, 2'b00, 32'h22, rd);
        access(3'd4, 1'b0, 2'b01, 0, rd);
        check("R4 misaligned half read", rd, 32'h0000_FFFF);
        check("R4 no request while misaligned", 32'(req_cnt - base), 32'd0);

        access(3'd0, 1'b1, 2'b10, 32'h8002_1A44, rd);
        access(3'd4, 1'b0, 2'b10, 0, rd);
        check("R3 R4 dropped writes left target intact", rd, 32'h8485_8687);

        access(3'd0, 1'b1, 2'b10, 32'h8005_0800, rd);
        base = req_cnt;
        access(3'd4, 1'b0, 2'b10, 0, rd);
        check("R8 no responder word", rd, 32'hFFFF_FFFF);
        access(3'd5, 1'b0, 2'b00, 0, rd);
        check("R8 no responder byte", rd, 32'h0000_00FF);
        check("R9 requests still issued", 32'(req_cnt - base), 32'd2);

        check("R9 no back-to-back strobes", 32'(dbl_strobe), 32'd0);
        check("R10 ready low while busy", 32'(ready_bad), 32'd0);
        check("R10 done is one cycle", 32'(done_bad), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R10 actual=hung expected=complete");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule